// File: doc/BRIEF.md
# Broadcast RF Level Modulator

This block turns a 3-bit video level into a signal that a simple resistor DAC can radiate as an RF carrier. On each fast clock it looks at a square-wave broadcast carrier input. While that input is low it drives the low member of a pair of DAC codes chosen by the level. While it is high it drives the high member. Black-of-sync gets the widest swing, and full white gets a constant code. An eight-level DC DAC therefore yields eight distinct AC amplitudes.

A fourth broadcast pin carries a sound subcarrier. It is formed by XORing one of several external FM carrier inputs with the broadcast carrier. A 2-bit mode decides what reaches the 8-bit output:
- the broadcast nibble and a plain baseband nibble, placed in either order on the two halves;
- the raw colour byte;
- nothing.

A chroma-enable bit chooses whether the broadcast path takes an upstream chroma-modulated level or the bare luminance.

Top module: `rf_level_mod`

## Requirements
- R1: With broadcast active, the three low pins of the broadcast nibble carry the pair member for the broadcast level. The pair is (lo, hi) = 0:(0,7), 1:(1,7), 2:(1,6), 3:(2,6), 4:(2,5), 5:(3,5), 6:(3,4), 7:(4,4). `lo` is driven while `carrier` is 0 and `hi` while it is 1.
- R2: Level 0 swings between 0 and 7. Level 7 gives 4 in both carrier phases. Low members never exceed 4, and high members are never below 4.
- R3: Bit 3 of the broadcast nibble equals `fm_in[fm_sel] ^ carrier`.
- R4: With `mode` = 2'b10, the broadcast nibble is on `dout[7:4]` and the baseband nibble is on `dout[3:0]`. With `mode` = 2'b11, the two nibbles swap halves.
- R5: With `mode` = 2'b01, `dout` equals `color`.
- R6: With `mode` = 2'b00, `dout` is all zero whatever the other inputs are.
- R7: The colour byte holds luminance in bits 2:0 and a modulate flag in bit 3. The broadcast level is `chroma_lvl` when `chroma_en` = 1 and `color[3]` = 1. Otherwise it is `color[2:0]`.
- R8: The baseband nibble is {0, level}. Its level is `chroma_lvl` when `color[3]` = 1 and `color[2:0]` otherwise, regardless of `chroma_en`.
- R9: While `rst_n` is low, `dout` is zero.
- R10: `dout` is registered: it reflects the inputs sampled at the previous rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast DAC clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Output arrangement: 00 off, 01 raw, 10 broadcast high, 11 broadcast low |
| chroma_en | input | 1 | Lets chroma-modulated levels into the broadcast path |
| color | input | 8 | Colour byte: [2:0] luminance, [3] modulate flag, [7:4] phase (unused here) |
| chroma_lvl | input | 3 | Upstream chroma-modulated level |
| carrier | input | 1 | Broadcast carrier square wave |
| fm_in | input | NFM | External FM sound carriers |
| fm_sel | input | SELW | Index of the sound carrier used |
| dout | output | 8 | Registered DAC pin codes |

## Verification
Some properties are checked on every cycle, with no reference model:
- the all-zero output in the off mode;
- raw pass-through;
- the sound pin's XOR;
- the zero top bit of the baseband nibble;
- the bound that places low-phase codes at or under 4 and high-phase codes at or above 4.

Other behaviour needs the bench's scenarios. These are the exact pair for each of the eight levels, the choice between chroma and luminance on each path, the nibble swap, and selection among the FM inputs. The bench checks them against a tabulated expectation at the cycle after each stimulus.

// File: rtl/rf_level_mod.sv
module rf_level_mod #(
  parameter int NFM = 8,
  localparam int SELW = (NFM > 1) ? $clog2(NFM) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            chroma_en,
  input  logic [7:0]      color,
  input  logic [2:0]      chroma_lvl,
  input  logic            carrier,
  input  logic [NFM-1:0]  fm_in,
  input  logic [SELW-1:0] fm_sel,
  output logic [7:0]      dout
);

  logic       modflag;
  logic [2:0] base_lvl, bc_lvl, lo_v, hi_v, rf_v;
  logic [3:0] lo_sum, bc_nib, bb_nib;
  logic       aural;
  logic [7:0] nxt;

  assign modflag  = color[3];
  assign base_lvl = modflag ? chroma_lvl : color[2:0];
  assign bc_lvl   = (chroma_en && modflag) ? chroma_lvl : color[2:0];

  assign lo_sum = {1'b0, bc_lvl} + 4'd1;
  assign lo_v   = lo_sum[3:1];
  assign hi_v   = 3'd7 - {1'b0, bc_lvl[2:1]};
  assign rf_v   = carrier ? hi_v : lo_v;

  assign aural  = fm_in[fm_sel] ^ carrier;
  assign bc_nib = {aural, rf_v};
  assign bb_nib = {1'b0, base_lvl};

  always_comb begin
    case (mode)
      2'b01:   nxt = color;
      2'b10:   nxt = {bc_nib, bb_nib};
      2'b11:   nxt = {bb_nib, bc_nib};
      default: nxt = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= 8'h00;
    else        dout <= nxt;
  end

  a_r6_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> dout == 8'h00);

  a_r5_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> dout == $past(color));

  a_r3_aural_pin: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> dout[7] == ($past(fm_in[fm_sel]) ^ $past(carrier)));

  a_r2_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !carrier) |=> dout[6:4] <= 3'd4);

  a_r2_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && carrier) |=> dout[2:0] >= 3'd4);

  a_r8_base_top: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> dout[7] == 1'b0);

endmodule

// File: tb/rf_level_mod_test.sv
module rf_level_mod_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] mode = 0;
  logic       chroma_en = 0;
  logic [7:0] color = 0;
  logic [2:0] chroma_lvl = 0;
  logic       carrier = 0;
  logic [7:0] fm_in = 0;
  logic [2:0] fm_sel = 0;
  logic [7:0] dout;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rf_level_mod uut (.clk(clk), .rst_n(rst_n), .mode(mode), .chroma_en(chroma_en),
    .color(color), .chroma_lvl(chroma_lvl), .carrier(carrier), .fm_in(fm_in),
    .fm_sel(fm_sel), .dout(dout));

  function automatic logic [2:0] pair_lo(input logic [2:0] l);
    case (l)
      3'd0: return 3'd0; 3'd1: return 3'd1; 3'd2: return 3'd1; 3'd3: return 3'd2;
      3'd4: return 3'd2; 3'd5: return 3'd3; 3'd6: return 3'd3; default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] pair_hi(input logic [2:0] l);
    case (l)
      3'd0: return 3'd7; 3'd1: return 3'd7; 3'd2: return 3'd6; 3'd3: return 3'd6;
      3'd4: return 3'd5; 3'd5: return 3'd5; default: return 3'd4;
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [1:0] m, input logic ce,
      input logic [7:0] c, input logic [2:0] cl, input logic cr,
      input logic [7:0] fi, input logic [2:0] fs);
    logic [2:0] bl, kl;
    logic [3:0] bn, kn;
    bl = (ce && c[3]) ? cl : c[2:0];
    kl = c[3] ? cl : c[2:0];
    bn = {fi[fs] ^ cr, cr ? pair_hi(bl) : pair_lo(bl)};
    kn = {1'b0, kl};
    case (m)
      2'b00: return 8'h00;
      2'b01: return c;
      2'b10: return {bn, kn};
      default: return {kn, bn};
    endcase
  endfunction

  task automatic drive(input logic [1:0] m, input logic ce, input logic [7:0] c,
      input logic [2:0] cl, input logic cr, input logic [7:0] fi,
      input logic [2:0] fs, input string tag);
    @(negedge clk);
    mode = m; chroma_en = ce; color = c; chroma_lvl = cl;
    carrier = cr; fm_in = fi; fm_sel = fs;
    exp_q.push_back(model(m, ce, c, cl, cr, fi, fs));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (dout !== e) begin
        failures++;
        $display("FAIL %s: dout=%h expected=%h", t, dout, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mode = 2'b01; color = 8'hA5;
    repeat (3) @(negedge clk);
    checks++;
    if (dout !== 8'h00) begin
      failures++;
      $display("FAIL R9: dout=%h expected=00", dout);
    end
    @(negedge clk);
    rst_n = 1;

    for (int l = 0; l < 8; l++)
      for (int p = 0; p < 2; p++)
        drive(2'b10, 1'b0, 8'(l), 3'd0, p[0], 8'h00, 3'd0, "R1/R2 pair table mode10");

    for (int l = 0; l < 8; l += 3)
      for (int p = 0; p < 2; p++)
        drive(2'b11, 1'b0, 8'(l) | 8'h50, 3'd0, p[0], 8'hFF, 3'd2, "R4 swapped nibbles");

    drive(2'b01, 1'b1, 8'h3C, 3'd6, 1'b1, 8'hFF, 3'd1, "R5 raw pass");
    drive(2'b01, 1'b0, 8'hC3, 3'd1, 1'b0, 8'h00, 3'd0, "R5 raw pass");
    drive(2'b00, 1'b1, 8'hFF, 3'd7, 1'b1, 8'hFF, 3'd7, "R6 off");
    drive(2'b00, 1'b0, 8'h0B, 3'd3, 1'b0, 8'h01, 3'd0, "R6 off");

    drive(2'b10, 1'b1, 8'h09, 3'd6, 1'b1, 8'h00, 3'd0, "R7 chroma on");
    drive(2'b10, 1'b1, 8'h09, 3'd6, 1'b0, 8'h00, 3'd0, "R7 chroma on");
    drive(2'b10, 1'b0, 8'h09, 3'd6, 1'b0, 8'h00, 3'd0, "R7 chroma off luma");
    drive(2'b10, 1'b1, 8'h05, 3'd0, 1'b1, 8'h00, 3'd0, "R7 flag clear luma");
    drive(2'b11, 1'b0, 8'h0A, 3'd5, 1'b0, 8'h00, 3'd0, "R8 base takes chroma");
    drive(2'b10, 1'b0, 8'h02, 3'd5, 1'b1, 8'h00, 3'd0, "R8 base takes luma");

    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 2; p++)
        drive(2'b10, 1'b0, 8'h03, 3'd0, p[0], 8'b0110_1001, 3'(s), "R3 aural select");

    for (int k = 0; k < 6; k++)
      drive(k[0] ? 2'b10 : 2'b01, 1'b0, 8'(k * 37), 3'd2, k[1], 8'h0F, 3'(k), "R10 per-cycle latency");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule